// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block holds the digital dividers of an integer-N frequency synthesizer. The local-oscillator clock drives a prescaler that divides by P or P+1 (P = 32 by default). A main counter and a swallow counter count the prescaler cycles, so that the overall division ratio equals a programmable 15-bit value N. A second, independent divider turns the crystal clock into the comparison frequency. It divides by 128, 64 or 80, chosen by a two-bit step code. Both divided outputs are single-cycle pulses that go to an external phase detector.

N is split into a main count M = N / P and a swallow count A = N mod P. In every output period the prescaler runs A cycles at P+1 and M−A cycles at P. This gives (P+1)·A + P·(M−A) = N local-oscillator cycles. A new ratio or step code is captured while the load strobe is high. It is only put into use at the next terminal count of the divider it belongs to, so no output period is ever cut short. The load strobe and its data must be held stable across at least one rising edge of each clock.

Top module: `synth_divider`

## Requirements
- R1: For every N from P·P (1024) to 2^15−1 (32767), the LO pulse output repeats every N cycles of the LO clock. The ratio input is an unsigned binary value, bit 14 weighted 2^14.
- R2: The prescaler counts P+1 cycles for each of the first A = N mod P prescaler cycles of an output period. It counts P cycles for each of the remaining M−A, where M = N / P. Its modulus changes only at the end of a prescaler cycle.
- R3: At the range ends, N = 1024 and N = 32767 give LO pulse periods of exactly 1024 and 32767 LO cycles.
- R4: With N = 3232 and step code 01, the LO period is 3232 cycles and the reference period is 128 cycles. With a 4 MHz crystal this places the synthesized frequency at 101 MHz.
- R5: The step code is step_i[1:0]. Code 01 divides the reference clock by 128, code 11 divides it by 64, and codes 00 and 10 divide it by 80.
- R6: A ratio captured with ld_i high takes effect only at the next LO terminal count. The LO period in progress completes at the old length, and the next period uses the new one.
- R7: A step code captured with ld_i high takes effect only at the next reference terminal count. The reference period in progress completes at the old length.
- R8: Each output pulse is high for exactly one cycle of its own input clock.
- R9: While rst_i is high at a clock edge, the output of that clock's domain is low and its counters are cleared. After reset, the ratio is 1024 and the step code is 11 (divide by 64).
- R10: Changes on ratio_i or step_i while ld_i is low have no effect on either output period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lo_clk_i | input | 1 | Local-oscillator clock (prescaler input) |
| ref_clk_i | input | 1 | Crystal reference clock |
| rst_i | input | 1 | Synchronous reset, sampled by both clocks |
| ld_i | input | 1 | Load strobe for ratio_i and step_i |
| ratio_i | input | N_W | Total division ratio N |
| step_i | input | 2 | Reference step code |
| lo_div_o | output | 1 | Divided LO pulse to the phase detector |
| ref_div_o | output | 1 | Divided reference pulse to the phase detector |

## Verification
The bench builds two instances. The first uses the default parameters (P = 32, 15-bit ratio) and covers both ends of the ratio range, the 3232 case, every step code, and the deferred-update behaviour on both dividers. The second is built with a prescaler of 4/5 and a 6-bit ratio. Its legal range then shrinks to 16…63, so every ratio, and every swallow count A from 0 to 3 against every main count M, can be swept exhaustively and compared with the arithmetic period.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

   typedef enum logic [1:0] {
      STEP_ALT_LO = 2'b00,
      STEP_FINE   = 2'b01,
      STEP_ALT_HI = 2'b10,
      STEP_MED    = 2'b11
   } step_e;

   // Reference divide ratio for a step code; bit 0 low selects the alternate ratio.
   function automatic int unsigned step_ratio(step_e s, int unsigned fine_div,
                                              int unsigned med_div, int unsigned alt_div);
      int unsigned r;
      case (s)
         STEP_FINE: r = fine_div;
         STEP_MED:  r = med_div;
         default:   r = alt_div;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
   parameter int PS_BITS = 5
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic mod_i,
   output logic tc_o
);
   localparam int P  = 1 << PS_BITS;
   localparam int CW = PS_BITS + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = mod_i ? CW'(P) : CW'(P - 1);
   assign tc_o = (cnt == last);

   always_ff @(posedge clk_i) begin
      if (rst_i)     cnt <= '0;
      else if (tc_o) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end

   // R2
   mod_steady_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !tc_o |=> $stable(mod_i));

   // R2
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt <= CW'(P));

endmodule

// File: rtl/swallow_ctr.sv
module swallow_ctr #(
   parameter int N_W     = 15,
   parameter int PS_BITS = 5,
   parameter int N_RST   = 1024
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           ld_i,
   input  logic [N_W-1:0] ratio_i,
   input  logic           pre_tc_i,
   output logic           mod_o,
   output logic           pulse_o
);
   localparam int M_W = N_W - PS_BITS;

   logic [N_W-1:0]     pend_n;
   logic [N_W-1:0]     act_n;
   logic [M_W-1:0]     m_cnt;
   logic [M_W-1:0]     m_val;
   logic [PS_BITS-1:0] a_val;
   logic               last;
   logic               term;

   assign m_val = act_n[N_W-1:PS_BITS];
   assign a_val = act_n[PS_BITS-1:0];
   assign mod_o = (m_cnt < M_W'(a_val));
   assign last  = (m_cnt == m_val - M_W'(1));
   assign term  = pre_tc_i && last;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_n  <= N_W'(N_RST);
         act_n   <= N_W'(N_RST);
         m_cnt   <= '0;
         pulse_o <= 1'b0;
      end else begin
         if (ld_i) pend_n <= ratio_i;
         pulse_o <= term;
         if (term) begin
            m_cnt <= '0;
            act_n <= pend_n;
         end else if (pre_tc_i) begin
            m_cnt <= m_cnt + M_W'(1);
         end
      end
   end

   // R6
   ratio_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !term |=> $stable(act_n));

   // R8
   lo_pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |=> !pulse_o);

   // R1
   main_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      m_cnt < m_val);

endmodule

// File: rtl/ref_divider.sv
module ref_divider
   import synth_div_pkg::*;
#(
   parameter int    FINE_DIV = 128,
   parameter int    MED_DIV  = 64,
   parameter int    ALT_DIV  = 80,
   parameter step_e RST_STEP = STEP_MED
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       ld_i,
   input  logic [1:0] step_i,
   output logic       pulse_o
);
   localparam int MAX_A = (FINE_DIV > MED_DIV) ? FINE_DIV : MED_DIV;
   localparam int MAX_R = (MAX_A > ALT_DIV) ? MAX_A : ALT_DIV;
   localparam int RW    = $clog2(MAX_R);

   step_e         pend_s;
   step_e         act_s;
   logic [RW-1:0] cnt;
   logic [RW-1:0] lim;
   logic          term;

   assign lim  = RW'(step_ratio(act_s, FINE_DIV, MED_DIV, ALT_DIV) - 1);
   assign term = (cnt == lim);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_s  <= RST_STEP;
         act_s   <= RST_STEP;
         cnt     <= '0;
         pulse_o <= 1'b0;
      end else begin
         if (ld_i) pend_s <= step_e'(step_i);
         pulse_o <= term;
         if (term) begin
            cnt   <= '0;
            act_s <= pend_s;
         end else begin
            cnt <= cnt + RW'(1);
         end
      end
   end

   // R7
   step_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !term |=> $stable(act_s));

   // R8
   ref_pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |=> !pulse_o);

   // R5
   ref_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt <= lim);

endmodule

// File: rtl/synth_divider.sv
module synth_divider
   import synth_div_pkg::*;
#(
   parameter int N_W      = 15,
   parameter int PS_BITS  = 5,
   parameter int FINE_DIV = 128,
   parameter int MED_DIV  = 64,
   parameter int ALT_DIV  = 80
) (
   input  logic           lo_clk_i,
   input  logic           ref_clk_i,
   input  logic           rst_i,
   input  logic           ld_i,
   input  logic [N_W-1:0] ratio_i,
   input  logic [1:0]     step_i,
   output logic           lo_div_o,
   output logic           ref_div_o
);
   localparam int P     = 1 << PS_BITS;
   localparam int N_MIN = P * P;

   if (N_W <= 2 * PS_BITS) begin : g_bad_width
      $error("ratio width must exceed twice the prescaler bits");
   end
   if (FINE_DIV < 2 || MED_DIV < 2 || ALT_DIV < 2) begin : g_bad_ref
      $error("reference ratios must be at least 2");
   end
   if (PS_BITS < 1) begin : g_bad_ps
      $error("prescaler needs at least one bit");
   end

   logic pre_tc;
   logic pre_mod;

   dm_prescaler #(.PS_BITS(PS_BITS)) u_pre (
      .clk_i (lo_clk_i),
      .rst_i (rst_i),
      .mod_i (pre_mod),
      .tc_o  (pre_tc)
   );

   swallow_ctr #(.N_W(N_W), .PS_BITS(PS_BITS), .N_RST(N_MIN)) u_swl (
      .clk_i    (lo_clk_i),
      .rst_i    (rst_i),
      .ld_i     (ld_i),
      .ratio_i  (ratio_i),
      .pre_tc_i (pre_tc),
      .mod_o    (pre_mod),
      .pulse_o  (lo_div_o)
   );

   ref_divider #(
      .FINE_DIV (FINE_DIV),
      .MED_DIV  (MED_DIV),
      .ALT_DIV  (ALT_DIV),
      .RST_STEP (STEP_MED)
   ) u_ref (
      .clk_i   (ref_clk_i),
      .rst_i   (rst_i),
      .ld_i    (ld_i),
      .step_i  (step_i),
      .pulse_o (ref_div_o)
   );

   // R1
   ratio_legal_chk: assert property (@(posedge lo_clk_i) disable iff (rst_i)
      ld_i |-> (ratio_i >= N_W'(N_MIN)));

   // R9
   reset_quiet_chk: assert property (@(posedge lo_clk_i)
      rst_i |=> !lo_div_o);

endmodule

// File: tb/tb_synth_divider.sv
`timescale 1ns/1ps
module tb_synth_divider;

   logic       ref_clk = 1'b0;
   logic       lo_clk  = 1'b0;
   logic       rst     = 1'b1;
   logic       ld      = 1'b0;
   logic [14:0] ratio  = 15'd1024;
   logic [5:0]  ratio_s = 6'd16;
   logic [1:0]  step   = 2'b11;
   logic        lo_div, ref_div, lo_div_s, ref_div_s;

   int checks = 0;
   int errors = 0;

   always #10 ref_clk = ~ref_clk;
   always #2  lo_clk  = ~lo_clk;

   synth_divider dut (
      .lo_clk_i(lo_clk), .ref_clk_i(ref_clk), .rst_i(rst), .ld_i(ld),
      .ratio_i(ratio), .step_i(step), .lo_div_o(lo_div), .ref_div_o(ref_div));

   synth_divider #(.N_W(6), .PS_BITS(2)) dut_small (
      .lo_clk_i(lo_clk), .ref_clk_i(ref_clk), .rst_i(rst), .ld_i(ld),
      .ratio_i(ratio_s), .step_i(step), .lo_div_o(lo_div_s), .ref_div_o(ref_div_s));

   // Interval monitors, sampled on falling edges
   int lo_cnt = 0, lo_iv = 0, lo_seen = 0;
   int los_cnt = 0, los_iv = 0, los_seen = 0;
   int rf_cnt = 0, rf_iv = 0, rf_seen = 0;
   int wide = 0;
   logic lo_prev = 0, los_prev = 0, rf_prev = 0;

   always @(negedge lo_clk) begin
      lo_cnt++; los_cnt++;
      if (lo_div)   begin lo_iv = lo_cnt; lo_cnt = 0; lo_seen++; end
      if (lo_div_s) begin los_iv = los_cnt; los_cnt = 0; los_seen++; end
      if ((lo_div && lo_prev) || (lo_div_s && los_prev)) wide++;
      lo_prev  = lo_div;
      los_prev = lo_div_s;
   end

   always @(negedge ref_clk) begin
      rf_cnt++;
      if (ref_div) begin rf_iv = rf_cnt; rf_cnt = 0; rf_seen++; end
      if (ref_div && rf_prev) wide++;
      rf_prev = ref_div;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load();
      @(negedge ref_clk); ld = 1'b1;
      @(negedge ref_clk);
      @(negedge ref_clk); ld = 1'b0;
   endtask

   task automatic wait_lo(input int n);
      int tgt = lo_seen + n;
      wait (lo_seen >= tgt);
   endtask

   task automatic wait_los(input int n);
      int tgt = los_seen + n;
      wait (los_seen >= tgt);
   endtask

   task automatic wait_rf(input int n);
      int tgt = rf_seen + n;
      wait (rf_seen >= tgt);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #3_000_000;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      // R9 reset state
      repeat (5) @(negedge ref_clk);
      chk(lo_div == 1'b0, "R9 lo low in reset", lo_div, 0);
      chk(ref_div == 1'b0, "R9 ref low in reset", ref_div, 0);
      rst = 1'b0;
      wait_lo(3);
      chk(lo_iv == 1024, "R9 default ratio", lo_iv, 1024);
      wait_rf(3);
      chk(rf_iv == 64, "R9 default step", rf_iv, 64);

      // R5 every step code
      for (int c = 0; c < 4; c++) begin
         int exp_r;
         exp_r = (c == 1) ? 128 : (c == 3) ? 64 : 80;
         step = 2'(c);
         load();
         wait_rf(3);
         chk(rf_iv == exp_r, "R5 step code", rf_iv, exp_r);
      end

      // R4 the 101 MHz setting
      ratio = 15'd3232; step = 2'b01;
      load();
      wait_lo(3); wait_rf(2);
      chk(lo_iv == 3232, "R4 lo period", lo_iv, 3232);
      chk(rf_iv == 128, "R4 ref period", rf_iv, 128);
      chk(64'd4_000_000 * 64'(lo_iv) / 64'(rf_iv) == 64'd101_000_000,
          "R4 synthesized Hz", 64'd4_000_000 * 64'(lo_iv) / 64'(rf_iv), 101_000_000);

      // R3 range ends
      ratio = 15'd1024; load(); wait_lo(3);
      chk(lo_iv == 1024, "R3 minimum ratio", lo_iv, 1024);
      ratio = 15'd32767; load(); wait_lo(3);
      chk(lo_iv == 32767, "R3 maximum ratio", lo_iv, 32767);

      // R6 deferred ratio update
      wait_lo(1);
      ratio = 15'd2000;
      load();
      wait_lo(1);
      chk(lo_iv == 32767, "R6 period in progress keeps old ratio", lo_iv, 32767);
      wait_lo(1);
      chk(lo_iv == 2000, "R6 next period uses new ratio", lo_iv, 2000);

      // R10 no load, no change
      ratio = 15'd5000; step = 2'b11;
      wait_lo(3); wait_rf(2);
      chk(lo_iv == 2000, "R10 ratio ignored without load", lo_iv, 2000);
      chk(rf_iv == 128, "R10 step ignored without load", rf_iv, 128);

      // R7 deferred step update (step_i already 11)
      ratio = 15'd2000;
      wait_rf(1);
      load();
      wait_rf(1);
      chk(rf_iv == 128, "R7 ref period in progress keeps old step", rf_iv, 128);
      wait_rf(1);
      chk(rf_iv == 64, "R7 next ref period uses new step", rf_iv, 64);

      // R1 R2 exhaustive sweep on the small build
      for (int n = 16; n < 64; n++) begin
         ratio_s = 6'(n);
         load();
         wait_los(3);
         chk(los_iv == n, "R1 R2 small ratio sweep", los_iv, n);
      end

      // R8 pulse width over the whole run
      chk(wide == 0, "R8 single-cycle pulses", wide, 0);
      summary();
   end

endmodule